// File: doc/BRIEF.md
# Received Frame Delivery with Status Trailer

The block sits between a receive buffer filled by the link side and user logic that consumes received frames one 32-bit dword per cycle. The link side writes entries through a plain write port. Each entry carries a dword and flags for first dword, last dword, bad frame and CRC failure. A separate abandon flag writes a marker that closes a frame early. The user side sees an active-low stream: a valid strobe, first and last markers, a ready input that acts as a stop request, a cancel input and an abort output.

Flow control works on a stop-latency basis rather than a per-beat handshake. While valid is low, every cycle carries one dword that the user must take. After the user raises its ready line, at most a few more dwords follow. Every frame that reaches its last dword is followed by one status dword. That dword travels as a single-dword packet with its type byte fixed at 0xEF, and it reports whether the frame was clean, bad or failed CRC. A frame that the user cancels or the link abandons is cut short. The rest of it is dropped from the buffer, and no status dword follows it.

Top module: `fis_rx_deliver`

## Requirements
- R1: While reset is high and after its release, `rx_vld_n`, `rx_sof_n`, `rx_eof_n` and `rx_abort_n` are high and `wr_full` is low.
- R2: Frame dwords leave in the order written, one per cycle in which `rx_vld_n` is low. `rx_sof_n` is low with the first dword of a frame and `rx_eof_n` is low with the last.
- R3: Each frame whose last dword is delivered is followed by exactly one status dword with `rx_sof_n` and `rx_eof_n` both low. In that dword, bits [7:0] = 0xEF, bit 26 = 1, and bits [31:27] and [23:8] are zero.
- R4: Status bits [25:24] are 10 when the CRC flag was set on the last dword written. Otherwise they are 01 when the bad flag was set, and otherwise 00.
- R5: Once `rx_rdy_n` is high, `rx_vld_n` is high from the (STOP_STAGES+1)-th cycle on, at most four cycles, and stays high until ready returns low.
- R6: A one-cycle low pulse on `rx_cancel_n` while a frame is in progress makes `rx_vld_n` high from the next cycle. The remaining dwords of that frame are discarded, no status dword follows, and the next frame starts normally with `rx_sof_n` low.
- R7: A cancel pulse while no frame is in progress has no effect on the dwords or status delivered afterwards.
- R8: An abandon marker written after part of a frame makes `rx_abort_n` low for exactly one cycle with `rx_vld_n` high. No further dwords or status of that frame appear.
- R9: `wr_full` goes high when DEPTH entries are stored and low again once the reader has taken one.
- R10: An abandon marker read while no frame is in progress is removed without any pulse on `rx_abort_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write one entry into the buffer |
| wr_sof | input | 1 | Entry is the first dword of a frame |
| wr_eof | input | 1 | Entry is the last dword of a frame |
| wr_bad | input | 1 | Frame malformed (read with last dword) |
| wr_crc | input | 1 | Frame failed CRC (read with last dword) |
| wr_abort | input | 1 | Entry is an abandon marker; data ignored |
| wr_data | input | 32 | Frame dword |
| wr_full | output | 1 | Buffer holds DEPTH entries |
| rx_data | output | 32 | Delivered dword |
| rx_sof_n | output | 1 | First dword marker, active low |
| rx_eof_n | output | 1 | Last dword marker, active low |
| rx_vld_n | output | 1 | Dword valid, active low |
| rx_rdy_n | input | 1 | User ready, active low |
| rx_cancel_n | input | 1 | User cancel of current frame, active low pulse |
| rx_abort_n | output | 1 | Frame abandoned by the link, active low pulse |

## Verification
A dword written while the path is idle and ready has been low for STOP_STAGES cycles leaves on the next clock edge. The status dword comes one cycle after the last dword when ready holds. A cancel takes effect on the edge that samples it, and the stop after ready rises falls within STOP_STAGES+1 edges. The bench samples outputs on the falling edge. It compares delivered beats in order against a queue of expected beats, so throttled ready does not shift any expected value. The stop bound is checked by counting falling edges since ready rose, and the cancel case is timed from the observed first-dword beat so that exactly two dwords are expected.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  localparam int DATA_W    = 32;
  localparam logic [7:0] STAT_TYPE = 8'hEF;

  typedef struct packed {
    logic              abrt;
    logic              sof;
    logic              eof;
    logic              bad;
    logic              crc;
    logic [DATA_W-1:0] data;
  } rxd_entry_t;

  localparam int ENTRY_W = $bits(rxd_entry_t);

  typedef enum logic [1:0] {
    SQ_DATA = 2'd0,
    SQ_STAT = 2'd1,
    SQ_DROP = 2'd2
  } rxd_state_e;

  // CRC failure outranks a malformed frame
  function automatic logic [DATA_W-1:0] status_word(input logic bad, input logic crc);
    logic [1:0] err;
    err = crc ? 2'b10 : (bad ? 2'b01 : 2'b00);
    return {5'd0, 1'b1, err, 16'd0, STAT_TYPE};
  endfunction

endpackage

// File: rtl/rxd_fifo.sv
module rxd_fifo #(
  parameter int W     = 37,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/rxd_go.sv
module rxd_go #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rdy_n,
  output logic go
);
  generate
    if (STAGES == 1) begin : g_one
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= ~rdy_n;
      end
      assign go = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], ~rdy_n};
      end
      assign go = sh[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/rxd_seq.sv
module rxd_seq
  import rxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  rxd_entry_t        head,
  input  logic              empty,
  input  logic              go,
  input  logic              cancel_n,
  output logic              pop,
  output logic [DATA_W-1:0] data,
  output logic              sof_n,
  output logic              eof_n,
  output logic              vld_n,
  output logic              abort_n
);
  rxd_state_e        state;
  logic              in_frame;
  logic [DATA_W-1:0] stat_q;
  logic              cut;

  assign cut = !cancel_n && in_frame;

  always_comb begin
    pop = 1'b0;
    if (state == SQ_DATA) pop = !cut && go && !empty;
    else if (state == SQ_DROP) pop = !empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SQ_DATA;
      in_frame <= 1'b0;
      stat_q   <= '0;
      data     <= '0;
      sof_n    <= 1'b1;
      eof_n    <= 1'b1;
      vld_n    <= 1'b1;
      abort_n  <= 1'b1;
    end else begin
      sof_n   <= 1'b1;
      eof_n   <= 1'b1;
      vld_n   <= 1'b1;
      abort_n <= 1'b1;
      case (state)
        SQ_DATA: begin
          if (cut) begin
            state    <= SQ_DROP;
            in_frame <= 1'b0;
          end else if (go && !empty) begin
            if (head.abrt) begin
              if (in_frame) abort_n <= 1'b0;
              in_frame <= 1'b0;
            end else begin
              vld_n <= 1'b0;
              data  <= head.data;
              sof_n <= ~head.sof;
              eof_n <= ~head.eof;
              if (head.eof) begin
                state    <= SQ_STAT;
                in_frame <= 1'b0;
                stat_q   <= status_word(head.bad, head.crc);
              end else begin
                in_frame <= 1'b1;
              end
            end
          end
        end
        SQ_STAT: begin
          if (go) begin
            vld_n <= 1'b0;
            sof_n <= 1'b0;
            eof_n <= 1'b0;
            data  <= stat_q;
            state <= SQ_DATA;
          end
        end
        SQ_DROP: begin
          if (!empty && (head.eof || head.abrt)) state <= SQ_DATA;
        end
        default: state <= SQ_DATA;
      endcase
    end
  end

endmodule

// File: rtl/fis_rx_deliver.sv
module fis_rx_deliver
  import rxd_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int STOP_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sof,
  input  logic              wr_eof,
  input  logic              wr_bad,
  input  logic              wr_crc,
  input  logic              wr_abort,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_sof_n,
  output logic              rx_eof_n,
  output logic              rx_vld_n,
  input  logic              rx_rdy_n,
  input  logic              rx_cancel_n,
  output logic              rx_abort_n
);
  rxd_entry_t         wr_ent, head;
  logic [ENTRY_W-1:0] head_bits;
  logic               empty, pop, go;

  always_comb begin
    wr_ent.abrt = wr_abort;
    wr_ent.sof  = wr_sof;
    wr_ent.eof  = wr_eof;
    wr_ent.bad  = wr_bad;
    wr_ent.crc  = wr_crc;
    wr_ent.data = wr_data;
  end

  assign head = rxd_entry_t'(head_bits);

  rxd_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) i_buf (
    .clk  (clk),
    .rst  (rst),
    .push (wr_en),
    .din  (wr_ent),
    .pop  (pop),
    .dout (head_bits),
    .empty(empty),
    .full (wr_full)
  );

  rxd_go #(.STAGES(STOP_STAGES)) i_go (
    .clk  (clk),
    .rst  (rst),
    .rdy_n(rx_rdy_n),
    .go   (go)
  );

  rxd_seq i_seq (
    .clk     (clk),
    .rst     (rst),
    .head    (head),
    .empty   (empty),
    .go      (go),
    .cancel_n(rx_cancel_n),
    .pop     (pop),
    .data    (rx_data),
    .sof_n   (rx_sof_n),
    .eof_n   (rx_eof_n),
    .vld_n   (rx_vld_n),
    .abort_n (rx_abort_n)
  );

endmodule

// File: rtl/rxd_chk.sv
module rxd_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] rx_data,
  input logic        rx_sof_n,
  input logic        rx_eof_n,
  input logic        rx_vld_n,
  input logic        rx_rdy_n,
  input logic        rx_cancel_n,
  input logic        rx_abort_n
);
  logic [2:0] hi_cnt;
  logic       stat_next;
  logic       frame_q, frame_eff, beat;

  assign beat = !rx_vld_n;

  always_comb begin
    frame_eff = frame_q;
    if (beat) frame_eff = !rx_eof_n ? 1'b0 : (!rx_sof_n ? 1'b1 : frame_q);
    else if (!rx_abort_n) frame_eff = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt    <= '0;
      stat_next <= 1'b0;
      frame_q   <= 1'b0;
    end else begin
      hi_cnt    <= rx_rdy_n ? ((hi_cnt == 3'd7) ? hi_cnt : hi_cnt + 1'b1) : '0;
      if (beat) stat_next <= stat_next ? 1'b0 : !rx_eof_n;
      frame_q   <= frame_eff && rx_cancel_n;
    end
  end

  assert_sof_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !rx_sof_n |-> !rx_vld_n);
  assert_eof_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !rx_eof_n |-> !rx_vld_n);
  assert_status_form_R3: assert property (@(posedge clk) disable iff (rst)
    (beat && stat_next) |-> (!rx_sof_n && !rx_eof_n && rx_data[7:0] == 8'hEF &&
                             rx_data[26] && rx_data[31:27] == 5'd0 && rx_data[23:8] == 16'd0));
  assert_status_err_R4: assert property (@(posedge clk) disable iff (rst)
    (beat && stat_next) |-> (rx_data[25:24] != 2'b11));
  assert_stop_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (hi_cnt >= 3'd4) |-> rx_vld_n);
  assert_cancel_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (!rx_cancel_n && frame_eff) |=> rx_vld_n);
  assert_abort_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    !rx_abort_n |=> rx_abort_n);
  assert_abort_novld_R8: assert property (@(posedge clk) disable iff (rst)
    !rx_abort_n |-> rx_vld_n);

endmodule

bind fis_rx_deliver rxd_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .rx_data    (rx_data),
  .rx_sof_n   (rx_sof_n),
  .rx_eof_n   (rx_eof_n),
  .rx_vld_n   (rx_vld_n),
  .rx_rdy_n   (rx_rdy_n),
  .rx_cancel_n(rx_cancel_n),
  .rx_abort_n (rx_abort_n)
);

// File: tb/test_fis_rx_deliver.sv
`timescale 1ns/1ps
module test_fis_rx_deliver;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0, wr_sof = 0, wr_eof = 0, wr_bad = 0, wr_crc = 0, wr_abort = 0;
  logic [31:0] wr_data = '0;
  logic        wr_full;
  logic [31:0] rx_data;
  logic        rx_sof_n, rx_eof_n, rx_vld_n, rx_abort_n;
  logic        rx_rdy_n = 1'b1, rx_cancel_n = 1'b1;

  int n_chk = 0, n_err = 0;
  int aborts_seen = 0, hi_cnt = 0;
  bit done = 0, throttle = 0;
  logic [34:0] expq[$];   // {is_status, sof, eof, data}

  always #2 clk = ~clk;

  fis_rx_deliver #(.DEPTH(DEPTH), .STOP_STAGES(2)) i_fis_rx_deliver (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sof(wr_sof), .wr_eof(wr_eof),
    .wr_bad(wr_bad), .wr_crc(wr_crc), .wr_abort(wr_abort), .wr_data(wr_data),
    .wr_full(wr_full), .rx_data(rx_data), .rx_sof_n(rx_sof_n), .rx_eof_n(rx_eof_n),
    .rx_vld_n(rx_vld_n), .rx_rdy_n(rx_rdy_n), .rx_cancel_n(rx_cancel_n),
    .rx_abort_n(rx_abort_n)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  function automatic logic [31:0] stat(input logic bad, input logic crc);
    return {5'd0, 1'b1, (crc ? 2'b10 : (bad ? 2'b01 : 2'b00)), 16'd0, 8'hEF};
  endfunction

  // beat monitor
  always @(negedge clk) begin
    if (!rst) begin
      hi_cnt = rx_rdy_n ? hi_cnt + 1 : 0;
      if (!rx_abort_n) aborts_seen++;
      if (!rx_vld_n) begin
        if (rx_rdy_n) check(hi_cnt <= 4, "R5 stop latency", 64'(hi_cnt), 64'd4);
        if (expq.size() == 0) begin
          check(0, "R2 unexpected beat", {30'd0, ~rx_sof_n, ~rx_eof_n, rx_data}, 64'd0);
        end else begin
          logic [34:0] e;
          e = expq.pop_front();
          check({~rx_sof_n, ~rx_eof_n, rx_data} == e[33:0],
                e[34] ? "R3/R4 status dword" : "R2 frame dword",
                {30'd0, ~rx_sof_n, ~rx_eof_n, rx_data}, {30'd0, e[33:0]});
        end
      end
    end
  end

  // caller is 1ns after a rising edge
  task automatic put(input logic s, input logic e, input logic b, input logic c,
                     input logic a, input logic [31:0] d);
    while (wr_full) begin @(posedge clk); #1; end
    wr_en = 1; wr_sof = s; wr_eof = e; wr_bad = b; wr_crc = c; wr_abort = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0; wr_sof = 0; wr_eof = 0; wr_bad = 0; wr_crc = 0; wr_abort = 0;
  endtask

  function automatic logic [31:0] dw(input int id, input int i);
    return 32'hA500_0000 + 32'(id * 256 + i);
  endfunction

  task automatic frame(input int id, input int len, input logic b, input logic c, input int keep);
    for (int i = 0; i < len; i++) begin
      if (i < keep) expq.push_back({1'b0, i == 0, i == len - 1, dw(id, i)});
      put(i == 0, i == len - 1, b, c, 1'b0, dw(id, i));
    end
    if (keep >= len) expq.push_back({1'b1, 1'b1, 1'b1, stat(b, c)});
  endtask

  task automatic drain();
    for (int k = 0; k < 3000 && expq.size() != 0; k++) begin @(posedge clk); #1; end
    repeat (10) begin @(posedge clk); #1; end
    check(expq.size() == 0, "R2 all expected beats delivered", 64'(expq.size()), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    fork
      forever begin
        @(posedge clk); #1;
        if (throttle) rx_rdy_n = (($time / 4) % 11) >= 7;
      end
    join_none

    repeat (3) @(negedge clk);
    check({rx_vld_n, rx_sof_n, rx_eof_n, rx_abort_n, wr_full} == 5'b11110, "R1 in reset",
          {59'd0, rx_vld_n, rx_sof_n, rx_eof_n, rx_abort_n, wr_full}, 64'h1E);
    @(posedge clk); #1; rst = 0;
    @(negedge clk);
    check({rx_vld_n, rx_sof_n, rx_eof_n, rx_abort_n, wr_full} == 5'b11110, "R1 after reset",
          {59'd0, rx_vld_n, rx_sof_n, rx_eof_n, rx_abort_n, wr_full}, 64'h1E);
    @(posedge clk); #1;

    // R2 R3 R4 R5: sweep over lengths and every flag combination under throttled ready
    throttle = 1;
    for (int len = 1; len <= 6; len++)
      for (int f = 0; f < 4; f++)
        frame(len * 4 + f, len, f[0], f[1], 99);
    drain();
    throttle = 0; rx_rdy_n = 0;
    drain();

    // R9: fill the buffer while stopped
    rx_rdy_n = 1;
    repeat (6) begin @(posedge clk); #1; end
    for (int i = 0; i < DEPTH; i++) begin
      expq.push_back({1'b0, i == 0, i == DEPTH - 1, dw(200, i)});
      put(i == 0, i == DEPTH - 1, 1'b0, 1'b1, 1'b0, dw(200, i));
      if (i == DEPTH - 2) check(wr_full == 0, "R9 not full below depth", 64'(wr_full), 64'd0);
    end
    expq.push_back({1'b1, 1'b1, 1'b1, stat(1'b0, 1'b1)});
    check(wr_full == 1, "R9 full at depth", 64'(wr_full), 64'd1);
    rx_rdy_n = 0;
    drain();
    check(wr_full == 0, "R9 full cleared", 64'(wr_full), 64'd0);

    // R6: cancel after two dwords of a six-dword frame
    rx_rdy_n = 1;
    repeat (6) begin @(posedge clk); #1; end
    frame(300, 6, 1'b1, 1'b0, 2);
    rx_rdy_n = 0;
    @(negedge clk);
    while (rx_vld_n || rx_sof_n) @(negedge clk);
    @(posedge clk); #1; rx_cancel_n = 0;
    @(posedge clk); #1; rx_cancel_n = 1;
    @(negedge clk);
    check(rx_vld_n == 1, "R6 valid high after cancel", 64'(rx_vld_n), 64'd1);
    @(posedge clk); #1;
    frame(301, 3, 1'b0, 1'b0, 99);
    drain();

    // R7: cancel with no frame in progress
    @(posedge clk); #1; rx_cancel_n = 0;
    @(posedge clk); #1; rx_cancel_n = 1;
    frame(400, 4, 1'b1, 1'b0, 99);
    drain();

    // R8: link abandons after three dwords; R10: stray marker
    for (int i = 0; i < 3; i++) begin
      expq.push_back({1'b0, i == 0, 1'b0, dw(500, i)});
      put(i == 0, 1'b0, 1'b0, 1'b0, 1'b0, dw(500, i));
    end
    put(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hDEAD_BEEF);
    drain();
    check(aborts_seen == 1, "R8 one abort pulse", 64'(aborts_seen), 64'd1);
    put(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0BAD_0BAD);
    frame(501, 2, 1'b0, 1'b1, 99);
    drain();
    check(aborts_seen == 1, "R10 stray marker gives no pulse", 64'(aborts_seen), 64'd1);

    done = 1;
    finish_run();
  end

endmodule